// File: doc/BRIEF.md
# Voice Codec Serial Frame Master

This block drives the timing-master side of a synchronous serial link between a voice sampling converter and a processor serial port. It divides its clock into a bit clock and raises a frame-sync pulse once every 256 bit clocks, which gives an 8 kHz frame rate from a 2.048 MHz bit clock. In each frame it shifts one 16-bit sample word out on `sdout` and captures one 16-bit word from `sdin`. Both words move MSB first. The outgoing bit changes on the rising bit-clock edge and the incoming bit is sampled on the falling edge.

When `mode_sub` is high, the link runs in a 15+1 arrangement. Bit 0 of a received primary word asks for a control frame, which the block then opens 128 bit clocks after the primary frame start, inside the same sample period. A control word either writes or reads one of four 8-bit configuration registers. For a read, the register value goes back in the low byte of the word the block sends during that same control frame. Holding `pwrdn_n` low stops all framing and shifting. The register contents are kept.

Top module: `voice_frame_master`

## Requirements
- R1: While `rst_n` is low, `sclk`, `fsync`, `sdout` and `rx_valid` are low, and `dac_word` and `cfg_flat` are zero.
- R2: `sclk` has a period of 2*HALF_DIV clock cycles with equal high and low time (2 cycles at the default HALF_DIV=1).
- R3: `fsync` rises together with a rising `sclk` and stays high for exactly one bit-clock period. With no control frames, consecutive frame syncs are 256 bit clocks apart.
- R4: `adc_word` is latched at the frame-sync rising edge, and its bit 15 is driven on `sdout` in that bit slot. The remaining bits follow MSB first, one per rising `sclk`.
- R5: `sdin` is sampled on falling `sclk`, MSB first. After the 16th bit of a primary frame, `dac_word` holds the word and `rx_valid` pulses high for exactly one clock.
- R6: If `mode_sub` is high when a primary word completes and that word's bit 0 is 1, a control frame with its own `fsync` pulse starts 128 bit clocks after the primary frame start. Otherwise no control frame follows. When `mode_sub` is low, control frames never occur.
- R7: A control word has this layout: bit 14 is 1 for a read and 0 for a write, bits 13:11 are the address, and bits 7:0 are the data. A write to address 0..3 loads `cfg_flat[8*a+7:8*a]` when the 16th bit is sampled. A write to address 4..7 changes nothing.
- R8: During a control frame the block sends 8'h00 in bits 15:8. In bits 7:0 it sends the addressed register for a read to address 0..3, and 8'h00 for any other read and for any write. A control frame changes neither `dac_word` nor `rx_valid`.
- R9: While `pwrdn_n` is low, `sclk`, `fsync`, `sdout` and `rx_valid` are low and `cfg_flat` is unchanged. After release, a new frame starts with `fsync` at the first rising `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwrdn_n | input | 1 | Active-low power-down; low stops the link |
| mode_sub | input | 1 | Enables 15+1 operation with control frames |
| adc_word | input | 16 | Sample word to send in each primary frame |
| sdin | input | 1 | Serial data from the processor port |
| sclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame-sync pulse, one bit clock wide |
| sdout | output | 1 | Serial data to the processor port |
| dac_word | output | 16 | Last received primary word |
| rx_valid | output | 1 | One-clock strobe when a primary word completes |
| cfg_flat | output | 32 | Four configuration bytes, register a at bits 8a+7:8a |

## Verification
The hardest case to reach from the ports is the read turnaround inside a control frame. In that case the register byte must appear on `sdout` from bit 7 onward, and its value depends on address bits that arrived only a few bit slots earlier in the same word. Getting there takes a two-frame sequence. The bench first plays a primary word with bit 0 set while `mode_sub` is high, which opens the control frame. It then shifts in a read word and compares the bits it samples on every rising edge against the register value it wrote in an earlier control frame. Out-of-range addresses, writes sent with 15+1 mode off, and a power-down window are driven the same way to show that nothing changes.

// File: rtl/vfm_pkg.sv
package vfm_pkg;
  localparam int WORD_W = 16;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int BYTE_W = WORD_W / 2;

  typedef logic [WORD_W-1:0] word_t;

  // control word: bit 14 read flag, bits 13:11 address, bits 7:0 data
  function automatic logic ctl_read(input word_t w);
    return w[14];
  endfunction

  function automatic logic [2:0] ctl_addr(input word_t w);
    return w[13:11];
  endfunction

  function automatic logic [BYTE_W-1:0] ctl_data(input word_t w);
    return w[BYTE_W-1:0];
  endfunction

  // serial bit for a given offset in the word, MSB first
  function automatic logic tx_bit(input word_t w, input logic [BIT_W-1:0] off);
    return w[BIT_W'(WORD_W-1) - off];
  endfunction
endpackage

// File: rtl/vfm_bitclk.sv
module vfm_bitclk #(
  parameter int HALF_DIV = 1,
  parameter int SLOT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic              sclk,
  output logic              rise_ev,
  output logic              fall_ev,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] nslot
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q;
  logic          tick;

  assign tick    = run && (div_q == DW'(HALF_DIV - 1));
  assign rise_ev = tick && !sclk;
  assign fall_ev = tick && sclk;
  assign nslot   = slot + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      div_q <= '0;
      sclk  <= 1'b0;
      slot  <= '1;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick)    sclk <= ~sclk;
      if (rise_ev) slot <= nslot;
    end
  end

  p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> sclk);
endmodule

// File: rtl/vfm_cfg.sv
module vfm_cfg
  import vfm_pkg::*;
#(
  parameter int N_REGS = 4,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_fire,
  input  word_t                    wr_word,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [BYTE_W-1:0]        rd_byte,
  output logic [N_REGS*BYTE_W-1:0] cfg_flat
);
  localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    logic              hit;
    assign hit = wr_fire && !ctl_read(wr_word) && (ctl_addr(wr_word) == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= ctl_data(wr_word);
    end
    assign cfg_flat[i*BYTE_W +: BYTE_W] = q;
  end

  logic [IDX_W-1:0] rd_idx;
  assign rd_idx  = rd_addr[IDX_W-1:0];
  assign rd_byte = (int'(rd_addr) < N_REGS) ? cfg_flat[rd_idx*BYTE_W +: BYTE_W] : '0;

  p_oob_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && int'(ctl_addr(wr_word)) >= N_REGS) |=> $stable(cfg_flat));
endmodule

// File: rtl/vfm_frame.sv
module vfm_frame
  import vfm_pkg::*;
#(
  parameter int SLOT_W   = 8,
  parameter int SEC_SLOT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              mode_sub,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic [SLOT_W-1:0] slot,
  input  logic [SLOT_W-1:0] nslot,
  input  word_t             adc_word,
  input  logic              sdin,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              fsync,
  output logic              sdout,
  output word_t             dac_word,
  output logic              rx_valid,
  output logic              wr_fire,
  output word_t             wr_word,
  output logic [2:0]        rd_addr
);
  localparam logic [SLOT_W-1:0] SEC_AT  = SLOT_W'(SEC_SLOT);
  localparam logic [SLOT_W-1:0] LAST    = SLOT_W'(WORD_W - 1);
  localparam logic [SLOT_W-1:0] TURN    = SLOT_W'(BYTE_W);
  localparam logic [SLOT_W-1:0] WLEN    = SLOT_W'(WORD_W);

  logic              pri_act, sec_act, sec_pend;
  word_t             tx_word;
  logic [WORD_W-2:0] rx_sh;
  logic [SLOT_W-1:0] base, off_r, off_n;
  word_t             hi_word, word_done;
  logic [BYTE_W-1:0] rd_now;
  logic              in_word, word_end;

  assign base      = sec_act ? SEC_AT : '0;
  assign off_r     = slot - base;
  assign off_n     = nslot - base;
  assign in_word   = pri_act || sec_act;
  assign word_end  = fall_ev && in_word && (off_r == LAST);
  assign word_done = {rx_sh, sdin};
  assign hi_word   = {rx_sh[BYTE_W-1:0], {BYTE_W{1'b0}}};
  assign rd_addr   = ctl_addr(hi_word);
  assign rd_now    = ctl_read(hi_word) ? rd_byte : '0;
  assign wr_fire   = word_end && sec_act;
  assign wr_word   = word_done;

  always_ff @(posedge clk) begin
    if (!rst_n) dac_word <= '0;
    else if (word_end && pri_act) dac_word <= word_done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      fsync <= 1'b0; sdout <= 1'b0; rx_valid <= 1'b0;
      pri_act <= 1'b0; sec_act <= 1'b0; sec_pend <= 1'b0;
      tx_word <= '0; rx_sh <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (rise_ev) begin
        if (nslot == '0) begin
          fsync <= 1'b1; pri_act <= 1'b1; rx_sh <= '0;
          tx_word <= adc_word; sdout <= adc_word[WORD_W-1];
        end else if (nslot == SEC_AT && sec_pend) begin
          fsync <= 1'b1; sec_act <= 1'b1; rx_sh <= '0;
          tx_word <= '0; sdout <= 1'b0;
        end else begin
          fsync <= 1'b0;
          if (in_word && off_n < WLEN) begin
            if (sec_act && off_n == TURN) begin
              sdout <= rd_now[BYTE_W-1];
              tx_word[BYTE_W-1:0] <= rd_now;
            end else begin
              sdout <= tx_bit(tx_word, off_n[BIT_W-1:0]);
            end
          end else begin
            sdout <= 1'b0;
          end
        end
      end
      if (fall_ev && in_word) begin
        rx_sh <= word_done[WORD_W-2:0];
        if (off_r == LAST) begin
          if (pri_act) begin
            pri_act  <= 1'b0;
            rx_valid <= 1'b1;
            sec_pend <= mode_sub && word_done[0];
          end else begin
            sec_act  <= 1'b0;
            sec_pend <= 1'b0;
          end
        end
      end
    end
  end

  p_fs_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> $past(rise_ev));
  p_fs_one_bclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && rise_ev) |=> !fsync);
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_ctl_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (!rx_valid && $stable(dac_word)));
endmodule

// File: rtl/voice_frame_master.sv
module voice_frame_master
  import vfm_pkg::*;
#(
  parameter int HALF_DIV   = 1,
  parameter int FRAME_BITS = 256,
  parameter int SEC_SLOT   = 128,
  parameter int N_REGS     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pwrdn_n,
  input  logic                     mode_sub,
  input  logic [WORD_W-1:0]        adc_word,
  input  logic                     sdin,
  output logic                     sclk,
  output logic                     fsync,
  output logic                     sdout,
  output logic [WORD_W-1:0]        dac_word,
  output logic                     rx_valid,
  output logic [N_REGS*BYTE_W-1:0] cfg_flat
);
  localparam int SLOT_W = $clog2(FRAME_BITS);

  logic              rise_ev, fall_ev, wr_fire;
  logic [SLOT_W-1:0] slot, nslot;
  logic [BYTE_W-1:0] rd_byte;
  logic [2:0]        rd_addr;
  word_t             wr_word;

  vfm_bitclk #(.HALF_DIV(HALF_DIV), .SLOT_W(SLOT_W)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(pwrdn_n), .sclk(sclk),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .slot(slot), .nslot(nslot));

  vfm_frame #(.SLOT_W(SLOT_W), .SEC_SLOT(SEC_SLOT)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(pwrdn_n), .mode_sub(mode_sub),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .slot(slot), .nslot(nslot),
    .adc_word(adc_word), .sdin(sdin), .rd_byte(rd_byte),
    .fsync(fsync), .sdout(sdout), .dac_word(dac_word), .rx_valid(rx_valid),
    .wr_fire(wr_fire), .wr_word(wr_word), .rd_addr(rd_addr));

  vfm_cfg #(.N_REGS(N_REGS), .ADDR_W(3)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_word(wr_word),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .cfg_flat(cfg_flat));

  p_pd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> (!sclk && !fsync && !sdout && !rx_valid && $stable(cfg_flat)));
endmodule

// File: tb/voice_frame_master_tb.sv
module voice_frame_master_tb;
  logic        clk = 1'b0;
  logic        rst_n, pwrdn_n, mode_sub, sdin;
  logic [15:0] adc_word;
  logic        sclk, fsync, sdout, rx_valid;
  logic [15:0] dac_word;
  logic [31:0] cfg_flat;

  int checks = 0, errors = 0;
  int cyc = 0, fs_hi = 0, fs_w = 0, vcnt = 0, last_fs = 0;
  logic fs_prev = 1'b0;

  localparam int BCLK_CYC  = 2;
  localparam int FRAME_CYC = 256 * BCLK_CYC;
  localparam int SEC_CYC   = 128 * BCLK_CYC;

  always #10 clk = ~clk;

  voice_frame_master u_dut (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .mode_sub(mode_sub),
    .adc_word(adc_word), .sdin(sdin), .sclk(sclk), .fsync(fsync),
    .sdout(sdout), .dac_word(dac_word), .rx_valid(rx_valid), .cfg_flat(cfg_flat));

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rx_valid) vcnt = vcnt + 1;
    if (fsync && !fs_prev) fs_hi = 1;
    else if (fsync) fs_hi = fs_hi + 1;
    else if (fs_prev) fs_w = fs_hi;
    fs_prev = fsync;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctlw(input logic rd, input logic [2:0] a, input logic [7:0] d);
    return {1'b0, rd, a, 3'b000, d};
  endfunction

  task automatic wait_rise();
    logic p;
    p = sclk;
    @(negedge clk);
    while (!(sclk && !p)) begin
      p = sclk;
      @(negedge clk);
    end
  endtask

  task automatic wait_fs(output int gap);
    int n = 0;
    wait_rise();
    while (!fsync && n < 2000) begin
      wait_rise();
      n++;
    end
    gap = cyc - last_fs;
    last_fs = cyc;
  endtask

  task automatic xfer(input logic [15:0] din, output logic [15:0] seen);
    for (int b = 15; b >= 0; b--) begin
      if (b != 15) wait_rise();
      seen[b] = sdout;
      sdin = din[b];
    end
    @(negedge clk);
    sdin = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 fsync", 32'(fsync), 0);
    chk("R1 sdout", 32'(sdout), 0);
    chk("R1 rx_valid", 32'(rx_valid), 0);
    chk("R1 dac_word", 32'(dac_word), 0);
    chk("R1 cfg_flat", cfg_flat, 0);
  endtask

  task automatic t_bitclk();
    int c0;
    wait_rise();
    c0 = cyc;
    chk("R2 high after rise", 32'(sclk), 1);
    wait_rise();
    chk("R2 period", 32'(cyc - c0), BCLK_CYC);
  endtask

  task automatic t_primary(input logic [15:0] adc, input logic [15:0] din,
                           input logic mode, input logic exp_sec);
    int g, v0;
    logic [15:0] seen;
    mode_sub = mode;
    adc_word = adc;
    wait_fs(g);
    v0 = vcnt;
    xfer(din, seen);
    chk("R4 sent word", 32'(seen), 32'(adc));
    chk("R5 dac_word", 32'(dac_word), 32'(din));
    chk("R5 rx_valid high", 32'(rx_valid), 1);
    chk("R3 fsync width", fs_w, BCLK_CYC);
    @(negedge clk);
    chk("R5 rx_valid one clock", 32'(rx_valid), 0);
    @(negedge clk);
    chk("R5 single strobe", vcnt - v0, 1);
    wait_fs(g);
    chk(exp_sec ? "R6 control frame follows" : "R6/R3 next primary", g,
        exp_sec ? SEC_CYC : FRAME_CYC);
  endtask

  task automatic t_ctrl(input logic [15:0] word, input logic [15:0] exp_seen);
    int g, v0;
    logic [15:0] seen, d0;
    v0 = vcnt;
    d0 = dac_word;
    xfer(word, seen);
    chk("R8 control reply", 32'(seen), 32'(exp_seen));
    @(negedge clk);
    @(negedge clk);
    chk("R8 no strobe", vcnt - v0, 0);
    chk("R8 dac_word kept", 32'(dac_word), 32'(d0));
    wait_fs(g);
    chk("R6 primary after control", g, SEC_CYC);
  endtask

  task automatic t_pwrdn();
    int v0, hi, c0;
    logic [31:0] k0;
    v0 = vcnt;
    k0 = cfg_flat;
    hi = 0;
    pwrdn_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      if (sclk || fsync || sdout || rx_valid) hi++;
      @(negedge clk);
    end
    chk("R9 pins quiet", hi, 0);
    chk("R9 no strobe", vcnt - v0, 0);
    chk("R9 cfg kept", cfg_flat, k0);
    c0 = cyc;
    pwrdn_n = 1'b1;
    wait_fs(hi);
    chk("R9 restart at first rise", 32'((cyc - c0) <= 2), 1);
  endtask

  initial begin
    rst_n = 1'b0; pwrdn_n = 1'b1; mode_sub = 1'b0; sdin = 1'b0; adc_word = 16'h0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_bitclk();
    t_primary(16'hC3A5, 16'h5A3C, 1'b0, 1'b0);
    t_primary(16'h8001, 16'h00FF, 1'b0, 1'b0);   // R6 request ignored, mode off
    t_primary(16'h7E81, 16'h1234, 1'b1, 1'b0);   // R6 bit 0 clear
    t_primary(16'h1111, 16'hA001, 1'b1, 1'b1);
    t_ctrl(ctlw(1'b0, 3'd2, 8'hA5), 16'h0000);  // R7 write
    chk("R7 reg2 written", cfg_flat, 32'h00A5_0000);
    t_primary(16'h2222, 16'h0003, 1'b1, 1'b1);
    t_ctrl(ctlw(1'b0, 3'd0, 8'h3C), 16'h0000);
    t_primary(16'h3333, 16'h0005, 1'b1, 1'b1);
    t_ctrl(ctlw(1'b0, 3'd3, 8'h96), 16'h0000);
    chk("R7 regs 0,2,3", cfg_flat, 32'h96A5_003C);
    t_primary(16'h4444, 16'h0007, 1'b1, 1'b1);
    t_ctrl(ctlw(1'b0, 3'd5, 8'hFF), 16'h0000);
    chk("R7 address 5 ignored", cfg_flat, 32'h96A5_003C);
    t_primary(16'h5555, 16'h0009, 1'b1, 1'b1);
    t_ctrl(ctlw(1'b1, 3'd2, 8'h00), 16'h00A5);  // R8 read
    t_primary(16'h6666, 16'h000B, 1'b1, 1'b1);
    t_ctrl(ctlw(1'b1, 3'd3, 8'h00), 16'h0096);
    t_primary(16'h7777, 16'h000D, 1'b1, 1'b1);
    t_ctrl(ctlw(1'b1, 3'd6, 8'h00), 16'h0000);  // R8 out of range read
    t_pwrdn();
    t_primary(16'h9ABC, 16'hDEF0, 1'b1, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule